// File: doc/BRIEF.md
# Virtual Output Queued Crossbar Switch

This block joins a set of input ports to a set of output ports through a crossbar. Each input keeps a separate queue for every output. An arriving word goes into the queue that its destination field selects, so a word held back by a busy output never delays words at the same input that are bound elsewhere. Head-of-line blocking is avoided by construction.

Each output has its own round-robin arbiter. In every cycle it picks one input whose queue for that output holds a word, and that word appears on the output. One input can win at several outputs in the same cycle, and then gives up one word from each winning queue. Each input offers a valid/ready handshake with a destination and a data word. Each output offers valid and data and has no back-pressure. A stored word is visible at an output in the cycle after it is accepted.

Top module: `voq_xbar`

## Requirements
- R1: A word with destination d that is presented with valid high at input i, while ready is high, is accepted at the clock edge. It later leaves on output d unchanged. Words from one input to one output leave in the order they were accepted.
- R2: An output asserts valid only in a cycle in which at least one input holds a word for it. It asserts valid in every such cycle. When no arbitration contends, a word accepted at an edge is on the output in the cycle after that edge.
- R3: Each output arbiter has a pointer that starts at input 0. It grants the first input, scanning upward from the pointer with wrap-around, whose queue for that output is non-empty. The pointer then moves to the input after the winner.
- R4: A word waiting at input i for a contended output does not delay a word at input i that is bound for a free output.
- R5: If one input holds words for several outputs and wins at each of them, each of those outputs carries a word from that input in the same cycle.
- R6: Input ready is low exactly when the queue chosen by the presented destination holds DEPTH words. An input that is not ready leaves that queue unchanged.
- R7: An asynchronous low reset empties all queues, returns all arbiter pointers to input 0, drives every output valid low and drives every input ready high.
- R8: When several inputs hold words for one output, that output carries one word per cycle. The others stay queued and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_IN | Per input: a word is presented |
| in_ready_o | output | N_IN | Per input: the selected queue has room |
| in_dest_i | input | N_IN x DEST_W | Per input: destination output index |
| in_data_i | input | N_IN x DATA_W | Per input: data word |
| out_valid_o | output | N_OUT | Per output: a word is delivered this cycle |
| out_data_o | output | N_OUT x DATA_W | Per output: delivered word |

## Verification
A corrupted queue count shows up as ready falling early or late under sustained load on one output. It also shows as words that are lost, duplicated or out of sequence in the per-input numbering of the drained stream, within a few cycles of the fault. An arbiter pointer that fails to advance or reset shows in the very next contended cycle: the same input wins twice in a row, or the wrong input wins first after reset. A crossbar or pop error shows as a word on the wrong output, or as a word missing one cycle after an uncontended push.

// File: rtl/voq_xbar_pkg.sv
package voq_xbar_pkg;
  // index width with a floor of one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/voq_fifo.sv
module voq_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned AW = voq_xbar_pkg::idx_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R1
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> ($stable(full_o) && $stable(empty_o)));
endmodule

// File: rtl/voq_rr_arb.sv
module voq_rr_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int unsigned IW = voq_xbar_pkg::idx_w(N);

  logic [IW-1:0] ptr;
  logic [IW-1:0] win;
  logic          found;

  // first requester at or after ptr, wrapping
  always_comb begin
    gnt_o = '0;
    win   = '0;
    found = 1'b0;
    for (int unsigned k = 0; k < N; k++) begin
      int unsigned j;
      j = (int'(ptr) + k) % N;
      if (!found && req_i[j]) begin
        found    = 1'b1;
        gnt_o[j] = 1'b1;
        win      = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr <= '0;
    else if (found) ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
  end

  // R8
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R3
  grant_to_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  // R2
  work_conserve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/voq_in_port.sv
module voq_in_port #(
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DEST_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [DEST_W-1:0]             dest_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic [N_OUT-1:0]              pop_i,
  output logic                          ready_o,
  output logic [N_OUT-1:0]              avail_o,
  output logic [N_OUT-1:0][DATA_W-1:0]  head_o
);
  localparam int unsigned NPAD = 2 ** DEST_W;

  logic [N_OUT-1:0] full, empty, push;
  logic [NPAD-1:0]  full_pad;

  // destinations beyond N_OUT see room and are discarded
  always_comb begin
    full_pad           = '0;
    full_pad[N_OUT-1:0] = full;
  end

  assign ready_o = !full_pad[dest_i];
  assign avail_o = ~empty;

  for (genvar o = 0; o < N_OUT; o++) begin : g_q
    assign push[o] = valid_i && ready_o && (dest_i == DEST_W'(o));
    voq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[o]),
      .data_i  (data_i),
      .pop_i   (pop_i[o]),
      .head_o  (head_o[o]),
      .full_o  (full[o]),
      .empty_o (empty[o])
    );
  end

  // R1
  single_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push));
endmodule

// File: rtl/voq_xbar.sv
module voq_xbar #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned DEST_W = voq_xbar_pkg::idx_w(N_OUT)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_IN-1:0]               in_valid_i,
  output logic [N_IN-1:0]               in_ready_o,
  input  logic [N_IN-1:0][DEST_W-1:0]   in_dest_i,
  input  logic [N_IN-1:0][DATA_W-1:0]   in_data_i,
  output logic [N_OUT-1:0]              out_valid_o,
  output logic [N_OUT-1:0][DATA_W-1:0]  out_data_o
);
  logic [N_OUT-1:0]             avail [N_IN];
  logic [N_OUT-1:0]             pop   [N_IN];
  logic [N_OUT-1:0][DATA_W-1:0] head  [N_IN];
  logic [N_IN-1:0]              req   [N_OUT];
  logic [N_IN-1:0]              gnt   [N_OUT];
  logic                         rdy   [N_IN];

  always_comb begin
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++) req[o][i] = avail[i][o];
    for (int i = 0; i < N_IN; i++)
      for (int o = 0; o < N_OUT; o++) pop[i][o] = gnt[o][i];
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    voq_in_port #(
      .N_OUT(N_OUT), .DATA_W(DATA_W), .DEPTH(DEPTH), .DEST_W(DEST_W)
    ) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (in_valid_i[i]),
      .dest_i  (in_dest_i[i]),
      .data_i  (in_data_i[i]),
      .pop_i   (pop[i]),
      .ready_o (rdy[i]),
      .avail_o (avail[i]),
      .head_o  (head[i])
    );
    assign in_ready_o[i] = rdy[i];
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    voq_rr_arb #(.N(N_IN)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req[o]),
      .gnt_o  (gnt[o])
    );
  end

  // crossbar: grants are one-hot, so an OR of gated heads selects the winner
  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      out_valid_o[o] = |gnt[o];
      out_data_o[o]  = '0;
      for (int i = 0; i < N_IN; i++)
        if (gnt[o][i]) out_data_o[o] = out_data_o[o] | head[i][o];
    end
  end
endmodule

// File: tb/voq_xbar_tb.sv
module voq_xbar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int DW = 8;
  localparam int DP = 4;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [NI-1:0]          in_valid;
  logic [NI-1:0]          in_ready;
  logic [NI-1:0][1:0]     in_dest;
  logic [NI-1:0][DW-1:0]  in_data;
  logic [NO-1:0]          out_valid;
  logic [NO-1:0][DW-1:0]  out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voq_xbar #(.N_IN(NI), .N_OUT(NO), .DATA_W(DW), .DEPTH(DP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_dest_i(in_dest), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // step: drive inputs for one cycle; expectation is for outputs seen before driving
  typedef struct packed {
    logic [3:0]       v;
    logic [3:0][1:0]  d;
    logic [3:0][7:0]  x;
    logic [3:0]       ev;
    logic [3:0][7:0]  ed;
  } step_t;

  localparam int NSTEP = 11;
  // fields listed input/output 3 down to 0
  localparam step_t TBL [NSTEP] = '{
    '{4'b0111, {2'd0,2'd1,2'd0,2'd0}, {8'h00,8'hC2,8'hB1,8'hA0}, 4'b0000, {8'h00,8'h00,8'h00,8'h00}},
    '{4'b0000, {2'd0,2'd0,2'd0,2'd0}, {8'h00,8'h00,8'h00,8'h00}, 4'b0011, {8'h00,8'h00,8'hC2,8'hA0}},
    '{4'b0000, {2'd0,2'd0,2'd0,2'd0}, {8'h00,8'h00,8'h00,8'h00}, 4'b0001, {8'h00,8'h00,8'h00,8'hB1}},
    '{4'b0011, {2'd0,2'd0,2'd2,2'd2}, {8'h00,8'h00,8'h20,8'h10}, 4'b0000, {8'h00,8'h00,8'h00,8'h00}},
    '{4'b0011, {2'd0,2'd0,2'd2,2'd3}, {8'h00,8'h00,8'h21,8'h30}, 4'b0100, {8'h00,8'h10,8'h00,8'h00}},
    '{4'b0000, {2'd0,2'd0,2'd0,2'd0}, {8'h00,8'h00,8'h00,8'h00}, 4'b1100, {8'h30,8'h20,8'h00,8'h00}},
    '{4'b0000, {2'd0,2'd0,2'd0,2'd0}, {8'h00,8'h00,8'h00,8'h00}, 4'b0100, {8'h00,8'h21,8'h00,8'h00}},
    '{4'b1100, {2'd0,2'd0,2'd0,2'd0}, {8'h50,8'h40,8'h00,8'h00}, 4'b0000, {8'h00,8'h00,8'h00,8'h00}},
    '{4'b0100, {2'd0,2'd1,2'd0,2'd0}, {8'h00,8'h41,8'h00,8'h00}, 4'b0001, {8'h00,8'h00,8'h00,8'h40}},
    '{4'b0000, {2'd0,2'd0,2'd0,2'd0}, {8'h00,8'h00,8'h00,8'h00}, 4'b0011, {8'h00,8'h00,8'h41,8'h50}},
    '{4'b0000, {2'd0,2'd0,2'd0,2'd0}, {8'h00,8'h00,8'h00,8'h00}, 4'b0000, {8'h00,8'h00,8'h00,8'h00}}
  };

  initial begin
    int cnt [2];
    int acc_seq [2];
    int pop_seq [2];
    int last;
    int src;
    bit dual;
    bit saw_full;
    bit pend3;
    logic [7:0] pend3_data;

    in_valid = '0; in_dest = '0; in_data = '0;
    repeat (3) @(negedge clk);
    // R7 state during reset
    check("R7 out_valid in reset", 32'(out_valid), 32'h0);
    check("R7 in_ready in reset", 32'(in_ready), 32'hF);
    rst_ni = 1'b1;

    // R1 R2 R3 R8 table; steps 4-5 and 8-9 cover R4
    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      for (int o = 0; o < NO; o++) begin
        check($sformatf("R2 step %0d out %0d valid", s, o), 32'(out_valid[o]), 32'(TBL[s].ev[o]));
        if (TBL[s].ev[o])
          check($sformatf("R1 R3 R4 R8 step %0d out %0d data", s, o), 32'(out_data[o]), 32'(TBL[s].ed[o]));
      end
      in_valid = TBL[s].v;
      in_dest  = TBL[s].d;
      in_data  = TBL[s].x;
      #1;
      check($sformatf("R6 step %0d ready", s), 32'(in_ready & TBL[s].v), 32'(TBL[s].v));
    end

    // sustained contention of inputs 0 and 1 on output 2
    cnt = '{0, 0}; acc_seq = '{0, 0}; pop_seq = '{0, 0};
    last = -1; dual = 1'b0; saw_full = 1'b0; pend3 = 1'b0; pend3_data = '0;
    for (int c = 0; c < 40; c++) begin
      int popsrc;
      @(negedge clk);
      popsrc = -1;
      check($sformatf("R2 fill c%0d out2 valid", c), 32'(out_valid[2]), 32'((cnt[0] > 0) || (cnt[1] > 0)));
      if (out_valid[2]) begin
        src = int'(out_data[2][7]);
        if (cnt[0] > 0 && cnt[1] > 0)
          check($sformatf("R3 fill c%0d winner", c), 32'(src), (last < 0) ? 32'd0 : 32'(1 - last));
        else
          check($sformatf("R8 fill c%0d winner", c), 32'(src), (cnt[0] > 0) ? 32'd0 : 32'd1);
        check($sformatf("R1 fill c%0d order", c), 32'(out_data[2][6:0]), 32'(pop_seq[src]));
        pop_seq[src]++;
        popsrc = src;
        last = src;
      end
      check($sformatf("R4 c%0d out3 valid", c), 32'(out_valid[3]), 32'(pend3));
      if (pend3) begin
        check($sformatf("R4 c%0d out3 data", c), 32'(out_data[3]), 32'(pend3_data));
        if (out_valid[2] && popsrc == 0) dual = 1'b1;
      end
      pend3 = 1'b0;
      in_valid = '0;
      if (c < 12) begin
        in_valid[0] = 1'b1; in_dest[0] = 2'd2; in_data[0] = {1'b0, 7'(acc_seq[0])};
        in_valid[1] = 1'b1; in_dest[1] = 2'd2; in_data[1] = {1'b1, 7'(acc_seq[1])};
      end
      if (c == 14 || c == 15) begin
        in_valid[0] = 1'b1; in_dest[0] = 2'd3; in_data[0] = 8'(8'h60 + c);
      end
      #1;
      if (c < 12) begin
        for (int i = 0; i < 2; i++) begin
          check($sformatf("R6 fill c%0d ready %0d", c, i), 32'(in_ready[i]), 32'(cnt[i] < DP));
          if (in_ready[i]) begin
            acc_seq[i]++;
            cnt[i]++;
          end else saw_full = 1'b1;
        end
      end
      if (c == 14 || c == 15) begin
        check($sformatf("R6 c%0d ready out3", c), 32'(in_ready[0]), 32'd1);
        pend3 = 1'b1;
        pend3_data = 8'(8'h60 + c);
      end
      if (popsrc >= 0) cnt[popsrc]--;
    end
    check("R6 ready fell at full", 32'(saw_full), 32'd1);
    check("R5 dual grant seen", 32'(dual), 32'd1);
    check("R8 no loss in0", 32'(pop_seq[0]), 32'(acc_seq[0]));
    check("R8 no loss in1", 32'(pop_seq[1]), 32'(acc_seq[1]));

    // reset with stored words, then pointer check
    in_valid = 4'b1100; in_dest = {2'd1, 2'd1, 2'd0, 2'd0}; in_data = {8'h93, 8'h92, 8'h00, 8'h00};
    @(negedge clk);
    check("R8 out1 valid", 32'(out_valid[1]), 32'd1);
    check("R3 out1 winner before reset", 32'(out_data[1]), 32'h93);
    in_valid = '0;
    rst_ni = 1'b0;
    #1;
    check("R7 out_valid async reset", 32'(out_valid), 32'h0);
    check("R7 in_ready async reset", 32'(in_ready), 32'hF);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R7 queues emptied", 32'(out_valid), 32'h0);
    in_valid = 4'b1100; in_dest = {2'd1, 2'd1, 2'd0, 2'd0}; in_data = {8'hA3, 8'hA2, 8'h00, 8'h00};
    @(negedge clk);
    check("R7 pointer cleared", 32'(out_data[1]), 32'hA2);
    in_valid = '0;
    @(negedge clk);
    check("R3 second word", 32'(out_data[1]), 32'hA3);
    @(negedge clk);
    check("R2 idle after drain", 32'(out_valid), 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule